// File: doc/BRIEF.md
# Hardware Cursor Overlay Renderer

This block paints a 64x64 monochrome cursor over a stream of 32-bit pixels. Software programs enable, position, pattern offset, hotspot and two colours through a small write-only register port. The video timing logic around it gives a frame pulse, a line pulse with the line number, and then the pixels of that line. For each pixel the block passes the background through, inverts it, or replaces it with one of the two colours. The choice comes from a two-plane pattern held in a byte memory.

When a line pulse arrives and the line falls inside the cursor, the block reads that row's 16 pattern bytes through a byte-wide read port with a one-cycle read latency. It holds them in a local row buffer. Position, pattern address and enable are copied into shadow state only at a frame pulse, so the cursor never tears within a frame. A lock bit in the offset register makes that copy keep the previous position and address. The cursor is clipped at the right edge and the bottom of the active display.

Top module: `hwcur_overlay`

## Requirements
- R1: After reset the output pixel is 0, `out_valid` is low, no memory read is issued, and no pixel is altered until a frame pulse has loaded an enabled cursor.
- R2: A pattern code with AND bit 1 and XOR bit 0 leaves the pixel unchanged.
- R3: A pattern code with AND bit 1 and XOR bit 1 outputs the bitwise complement of all 32 bits of the input pixel.
- R4: A pattern code with AND bit 0 outputs colour1 (register 5) when XOR is 1 and colour0 (register 4) when XOR is 0. Only bits 23:0 of each colour register are kept, and the output's bits 31:24 are forced to 0xFF.
- R5: Each cursor row is 16 bytes. Bytes 0-7 are the AND plane and bytes 8-15 are the XOR plane. Byte i covers cursor columns 8i..8i+7, and the most significant bit is the leftmost column.
- R6: The cursor covers lines Y..Y+63, where Y is bits 15:0 of the position register (register 1). A covered line reads exactly 16 bytes, at addresses base+16*row .. base+16*row+15. An uncovered line reads nothing.
- R7: The cursor covers pixel columns X..X+63, where X is bits 31:16 of the position register. Every other column passes through unchanged.
- R8: Columns at or beyond (H+1)*8 are never altered, where H is bits 31:16 of register 6. The cursor never spills past that edge.
- R9: Lines whose number exceeds V, bits 31:16 of register 7, receive no cursor and cause no memory reads.
- R10: The pattern base address is offset bits 26:0 (register 2), minus the horizontal hotspot (register 3, bits 21:16), minus 16 times the vertical hotspot (register 3, bits 5:0), taken modulo 2^AW.
- R11: While offset bit 31 is set, a frame pulse keeps the previously displayed position and base address.
- R12: Writes to enable (register 0, bit 0), position, offset and hotspot take effect only at the next frame pulse.
- R13: Each pixel result appears one clock after its input pixel. The row reads are issued on the 16 clocks that follow the line pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select, 0..7 |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame pulse, loads the shadow state |
| line_start | input | 1 | Line pulse, starts the row fetch |
| line_y | input | 16 | Line number qualified by line_start |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Column of the input pixel |
| pix_in | input | 32 | Background pixel |
| out_valid | output | 1 | Output pixel valid |
| pix_out | output | 32 | Composed pixel |
| mem_rd | output | 1 | Pattern read request |
| mem_addr | output | AW (12) | Pattern byte address |
| mem_rdata | input | 8 | Pattern byte, valid one clock after the request |

## Verification
A pixel driven in one cycle comes out registered after the next clock edge. The bench pushes its expected value into a queue when it drives the pixel, and the monitor pops and compares it on the falling edge after that. A row fetch puts 16 reads on the port in the 16 cycles after the line pulse, and with the one-cycle memory latency the row buffer is complete 18 cycles after the pulse. The bench therefore drives no pixels until 20 cycles after each line pulse. Over that window it counts the reads and records the first address. Shadow updates happen only on frame pulses, so the bench's own register model copies its shadow at the same pulses.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
  localparam int CUR_DIM   = 64;
  localparam int ROW_BYTES = 16;

  localparam logic [2:0] SEL_CTRL = 3'd0;
  localparam logic [2:0] SEL_POS  = 3'd1;
  localparam logic [2:0] SEL_OFFS = 3'd2;
  localparam logic [2:0] SEL_HOT  = 3'd3;
  localparam logic [2:0] SEL_CLR0 = 3'd4;
  localparam logic [2:0] SEL_CLR1 = 3'd5;
  localparam logic [2:0] SEL_HTIM = 3'd6;
  localparam logic [2:0] SEL_VTIM = 3'd7;

  // active width in pixels from the horizontal display field
  function automatic logic [19:0] line_width(input logic [15:0] hdisp);
    return ({4'd0, hdisp} + 20'd1) << 3;
  endfunction

  // pattern start address after hotspot adjustment
  function automatic logic [31:0] pattern_base(input logic [31:0] offs,
                                               input logic [31:0] hot);
    return {5'd0, offs[26:0]} - {16'd0, hot[31:16]} - {12'd0, hot[15:0], 4'd0};
  endfunction

  // two-plane pixel decode
  function automatic logic [31:0] shade(input logic and_b, input logic xor_b,
                                        input logic [31:0] bg,
                                        input logic [23:0] c0,
                                        input logic [23:0] c1);
    if (and_b) return xor_b ? ~bg : bg;
    return {8'hFF, (xor_b ? c1 : c0)};
  endfunction
endpackage

// File: rtl/hwcur_regs.sv
module hwcur_regs
  import hwcur_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          frame_start,
  output logic          sh_en,
  output logic [15:0]   sh_x,
  output logic [15:0]   sh_y,
  output logic [AW-1:0] sh_base,
  output logic [23:0]   clr0,
  output logic [23:0]   clr1,
  output logic [15:0]   hdisp,
  output logic [15:0]   vdisp,
  output logic          locked
);
  logic        ctrl_q;
  logic [31:0] pos_q, offs_q, hot_q;

  assign locked = offs_q[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0; pos_q <= '0; offs_q <= '0; hot_q <= '0;
      clr0 <= '0; clr1 <= '0; hdisp <= '0; vdisp <= '0;
      sh_en <= 1'b0; sh_x <= '0; sh_y <= '0; sh_base <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: ctrl_q <= wr_data[0];
          SEL_POS:  pos_q  <= wr_data;
          SEL_OFFS: offs_q <= wr_data;
          SEL_HOT:  hot_q  <= wr_data & 32'h003F_003F;
          SEL_CLR0: clr0   <= wr_data[23:0];
          SEL_CLR1: clr1   <= wr_data[23:0];
          SEL_HTIM: hdisp  <= wr_data[31:16];
          SEL_VTIM: vdisp  <= wr_data[31:16];
          default:  ;
        endcase
      end
      if (frame_start) begin
        sh_en <= ctrl_q;
        if (!offs_q[31]) begin
          sh_x    <= pos_q[31:16];
          sh_y    <= pos_q[15:0];
          sh_base <= AW'(pattern_base(offs_q, hot_q));
        end
      end
    end
  end
endmodule

// File: rtl/hwcur_fetch.sv
module hwcur_fetch
  import hwcur_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [15:0]   line_y,
  input  logic          sh_en,
  input  logic [15:0]   sh_y,
  input  logic [AW-1:0] sh_base,
  input  logic [15:0]   vdisp,
  input  logic [7:0]    mem_rdata,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic          row_hit,
  output logic [63:0]   and_plane,
  output logic [63:0]   xor_plane
);
  localparam int CW = $clog2(ROW_BYTES);

  logic [16:0]   dy;
  logic          hit_now;
  logic          busy, rd_q;
  logic [CW-1:0] cnt, idx_q;
  logic [AW-1:0] row_base;
  logic [7:0]    rowbuf [ROW_BYTES];

  assign dy      = {1'b0, line_y} - {1'b0, sh_y};
  assign hit_now = sh_en && (line_y >= sh_y) && (dy < 17'(CUR_DIM)) && (line_y <= vdisp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_hit <= 1'b0; busy <= 1'b0; cnt <= '0; row_base <= '0;
      rd_q <= 1'b0; idx_q <= '0;
    end else begin
      rd_q  <= mem_rd;
      idx_q <= cnt;
      if (line_start) begin
        row_hit  <= hit_now;
        busy     <= hit_now;
        cnt      <= '0;
        row_base <= sh_base + {{(AW-10){1'b0}}, dy[5:0], 4'b0000};
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(ROW_BYTES - 1)) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_q) rowbuf[idx_q] <= mem_rdata;
  end

  assign mem_rd   = busy;
  assign mem_addr = row_base + AW'(cnt);

  for (genvar b = 0; b < ROW_BYTES / 2; b++) begin : g_planes
    assign and_plane[63 - 8*b -: 8] = rowbuf[b];
    assign xor_plane[63 - 8*b -: 8] = rowbuf[b + ROW_BYTES / 2];
  end
endmodule

// File: rtl/hwcur_pixel.sv
module hwcur_pixel
  import hwcur_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_valid,
  input  logic [15:0] pix_x,
  input  logic [31:0] pix_in,
  input  logic        row_hit,
  input  logic [15:0] sh_x,
  input  logic [63:0] and_plane,
  input  logic [63:0] xor_plane,
  input  logic [23:0] clr0,
  input  logic [23:0] clr1,
  input  logic [15:0] hdisp,
  output logic        cov,
  output logic        out_valid,
  output logic [31:0] pix_out
);
  logic [16:0] dx;
  logic [19:0] width;
  logic [5:0]  bit_idx;
  logic [31:0] blend;

  assign dx      = {1'b0, pix_x} - {1'b0, sh_x};
  assign width   = line_width(hdisp);
  assign cov     = row_hit && (pix_x >= sh_x) && (dx < 17'(CUR_DIM)) && ({4'd0, pix_x} < width);
  assign bit_idx = 6'd63 - dx[5:0];
  assign blend   = shade(and_plane[bit_idx], xor_plane[bit_idx], pix_in, clr0, clr1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) pix_out <= cov ? blend : pix_in;
    end
  end
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
  import hwcur_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic [15:0]   line_y,
  input  logic          pix_valid,
  input  logic [15:0]   pix_x,
  input  logic [31:0]   pix_in,
  output logic          out_valid,
  output logic [31:0]   pix_out,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);
  logic          sh_en, locked, row_hit, cov;
  logic [15:0]   sh_x, sh_y, hdisp, vdisp;
  logic [AW-1:0] sh_base;
  logic [23:0]   clr0, clr1;
  logic [63:0]   and_plane, xor_plane;

  hwcur_regs #(.AW(AW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .frame_start(frame_start), .sh_en(sh_en), .sh_x(sh_x), .sh_y(sh_y),
    .sh_base(sh_base), .clr0(clr0), .clr1(clr1), .hdisp(hdisp), .vdisp(vdisp),
    .locked(locked)
  );

  hwcur_fetch #(.AW(AW)) fetch_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y),
    .sh_en(sh_en), .sh_y(sh_y), .sh_base(sh_base), .vdisp(vdisp),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .row_hit(row_hit), .and_plane(and_plane), .xor_plane(xor_plane)
  );

  hwcur_pixel pixel_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_x(pix_x), .pix_in(pix_in),
    .row_hit(row_hit), .sh_x(sh_x), .and_plane(and_plane), .xor_plane(xor_plane),
    .clr0(clr0), .clr1(clr1), .hdisp(hdisp), .cov(cov),
    .out_valid(out_valid), .pix_out(pix_out)
  );
endmodule

// File: rtl/hwcur_overlay_chk.sv
module hwcur_overlay_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_valid,
  input logic [31:0] pix_in,
  input logic        out_valid,
  input logic [31:0] pix_out,
  input logic        cov,
  input logic        mem_rd,
  input logic        row_hit,
  input logic        frame_start,
  input logic        locked,
  input logic [15:0] sh_x,
  input logic [15:0] sh_y
);
  // R13: a result follows every input pixel one clock later
  assert_latency_R13: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  // R7: pixels outside the cursor window come out untouched
  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !cov) |=> (pix_out == $past(pix_in)));

  // R6: pattern reads only on a covered line
  assert_fetch_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> row_hit);

  // R11: a locked frame pulse keeps the displayed position
  assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && locked) |=> ($stable(sh_x) && $stable(sh_y)));
endmodule

bind hwcur_overlay hwcur_overlay_chk chk_i (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
  .out_valid(out_valid), .pix_out(pix_out), .cov(cov), .mem_rd(mem_rd),
  .row_hit(row_hit), .frame_start(frame_start), .locked(locked),
  .sh_x(sh_x), .sh_y(sh_y)
);

// File: tb/hwcur_overlay_tb.sv
module hwcur_overlay_tb_top;
  localparam int AW = 12;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0; logic [2:0] reg_sel = '0; logic [31:0] reg_wdata = '0;
  logic frame_start = 1'b0, line_start = 1'b0; logic [15:0] line_y = '0;
  logic pix_valid = 1'b0; logic [15:0] pix_x = '0; logic [31:0] pix_in = '0;
  logic out_valid; logic [31:0] pix_out;
  logic mem_rd; logic [AW-1:0] mem_addr; logic [7:0] mem_rdata = '0;

  always #10 clk = ~clk;

  hwcur_overlay #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .frame_start(frame_start), .line_start(line_start), .line_y(line_y),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_in(pix_in),
    .out_valid(out_valid), .pix_out(pix_out),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(((a * 73) + 17) ^ (a >> 3));
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_addr));

  // bench register model
  logic        l_en = 0; logic [31:0] l_pos = 0, l_off = 0, l_hot = 0;
  logic [31:0] l_c0 = 0, l_c1 = 0, l_htim = 0, l_vtim = 0;
  logic        m_en = 0; int m_x = 0, m_y = 0, m_base = 0;

  int n_chk = 0, n_bad = 0, rd_cnt = 0, first_addr = -1;
  logic [31:0] exp_q[$]; string tag_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_pix(int x, int y, logic [31:0] bg);
    int dx, dy, width, a;
    logic [7:0] ab, xb;
    logic an, xo;
    width = (int'(l_htim[31:16]) + 1) * 8;
    dy = y - m_y; dx = x - m_x;
    if (!m_en || dy < 0 || dy > 63 || y > int'(l_vtim[31:16]) ||
        dx < 0 || dx > 63 || x >= width) return bg;
    a  = m_base + dy * 16 + dx / 8;
    ab = pat(a & AMASK);
    xb = pat((a + 8) & AMASK);
    an = ab[7 - dx % 8]; xo = xb[7 - dx % 8];
    if (an) return xo ? ~bg : bg;
    return {8'hFF, (xo ? l_c1[23:0] : l_c0[23:0])};
  endfunction

  task automatic wreg(input int sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = 3'(sel); reg_wdata = d;
    case (sel)
      0: l_en = d[0]; 1: l_pos = d; 2: l_off = d; 3: l_hot = d & 32'h003F003F;
      4: l_c0 = d; 5: l_c1 = d; 6: l_htim = d; default: l_vtim = d;
    endcase
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic frame();
    @(negedge clk); frame_start = 1;
    m_en = l_en;
    if (!l_off[31]) begin
      m_x = int'(l_pos[31:16]); m_y = int'(l_pos[15:0]);
      m_base = (int'(l_off[26:0]) - int'(l_hot[31:16]) - 16 * int'(l_hot[15:0])) & AMASK;
    end
    @(negedge clk); frame_start = 0;
  endtask

  task automatic line(input int y, input string tag);
    bit hit;
    hit = m_en && y >= m_y && (y - m_y) < 64 && y <= int'(l_vtim[31:16]);
    rd_cnt = 0; first_addr = -1;
    @(negedge clk); line_start = 1; line_y = 16'(y);
    @(negedge clk); line_start = 0;
    repeat (20) @(negedge clk);
    check(rd_cnt == (hit ? 16 : 0), {tag, " R13 read count"}, rd_cnt, hit ? 16 : 0);
    if (hit) check(first_addr == ((m_base + (y - m_y) * 16) & AMASK),
                   {tag, " R10 row address"}, first_addr, (m_base + (y - m_y) * 16) & AMASK);
  endtask

  task automatic run_px(input int y, input int x0, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [31:0] bg;
      bg = 32'h5A3C_9612 ^ (32'(x0 + i) * 32'h0101_0107);
      @(negedge clk); pix_valid = 1; pix_x = 16'(x0 + i); pix_in = bg;
      exp_q.push_back(ref_pix(x0 + i, y, bg)); tag_q.push_back(tag);
    end
    @(negedge clk); pix_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: read counter and scoreboard
  always @(negedge clk) begin
    if (mem_rd) begin
      if (rd_cnt == 0) first_addr = int'(mem_addr);
      rd_cnt++;
    end
    if (out_valid) begin
      if (exp_q.size() == 0) check(0, "R13 unexpected output", pix_out, 0);
      else begin
        logic [31:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(pix_out == e, t, pix_out, e);
      end
    end
  end

  bit done = 0;
  initial begin
    #(20ns * 200000);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pix_out == 0, "R1 reset pixel", pix_out, 0);
    check(out_valid == 0, "R1 reset valid", out_valid, 0);
    check(mem_rd == 0, "R1 reset read", mem_rd, 0);
    rst_n = 1;
    run_px(0, 0, 8, "R1 no cursor before frame");

    wreg(6, 32'd79 << 16); wreg(7, 32'd479 << 16);
    wreg(4, 32'h0011_2233); wreg(5, 32'hAB44_5566);
    wreg(2, 32'h100); wreg(3, 0); wreg(1, (32'd100 << 16) | 32'd50); wreg(0, 1);
    run_px(50, 98, 8, "R12 enable waits for frame");
    frame();
    line(50, "R6 first row");
    run_px(50, 96, 74, "R2 R3 R4 R5 R7 decode row 0");
    line(113, "R6 last row");
    run_px(113, 96, 74, "R5 R7 decode row 63");
    line(114, "R6 below cursor");
    run_px(114, 96, 20, "R6 line below");
    line(49, "R6 above cursor");
    run_px(49, 96, 20, "R6 line above");

    wreg(3, (32'd3 << 16) | 32'd2);
    frame();
    line(60, "R10 hotspot");
    run_px(60, 100, 64, "R10 hotspot pattern");

    wreg(2, 32'h8000_0100); wreg(1, (32'd10 << 16) | 32'd5);
    frame();
    line(52, "R11 locked");
    run_px(52, 96, 40, "R11 locked position kept");
    line(5, "R11 locked new line");
    wreg(2, 32'h200);
    frame();
    line(5, "R11 unlocked");
    run_px(5, 8, 70, "R11 new position applied");

    wreg(1, (32'd60 << 16) | 32'd15);
    line(5, "R12 pending position");
    run_px(5, 8, 20, "R12 old position still shown");
    wreg(6, 32'd11 << 16); wreg(7, 32'd20 << 16);
    frame();
    line(20, "R8 clip");
    run_px(20, 56, 75, "R8 right edge clip");
    line(21, "R9 past display end");
    run_px(21, 56, 40, "R9 no cursor below display");
    line(15, "R9 top row");
    run_px(15, 58, 40, "R4 R8 top row clipped");

    wreg(0, 0);
    line(20, "R12 disable pending");
    run_px(20, 60, 16, "R12 still drawn");
    frame();
    line(20, "R12 disabled");
    run_px(20, 60, 16, "R12 disabled no cursor");

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R13 outputs outstanding", exp_q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule